// File: doc/BRIEF.md
# Byte-Parity Checked Single-Port RAM

This block wraps a single-port data RAM and stores one extra bit for every byte. That bit holds the byte's even parity. Writes go in over a valid/ready request bus with per-byte enables, and each written lane gets its parity bit refreshed. Reads recompute the parity of each returned byte and compare it with the stored bit. When detection is on and a lane disagrees, three things happen:

- The response for that read carries an error flag, while still returning the raw data.
- The first such event is captured in a status register: a sticky flag, the mask of failing lanes and the word address.
- A level interrupt rises.

A small register port carries two settings. One is the detection enable. The other is a diagnostic bit that makes writes store inverted parity, so software can plant faults on purpose. The status register is cleared by writing one to its flag bit.

After reset the wrapper sweeps the whole array and writes zero data with matching parity. It holds the request bus not-ready during that sweep. Every accepted request gets exactly one response in the following cycle.

Top module: `par_guard_ram`

## Requirements
- R1: After reset, `reqReady` stays low while the array is cleared (at most DEPTH+2 cycles). Then it goes high. Every word reads back as zero with no error. Control, status and `irq` read as zero.
- R2: An accepted request (`reqValid` and `reqReady` high at a clock edge) produces `rspValid` high for exactly the next cycle. A read returns the word last written.
- R3: A write updates only the bytes whose `reqBe` bit is set (bit i covers data bits 8i+7..8i). The other bytes keep their contents.
- R4: Each written lane stores its even parity (XOR of the byte), or the inverse of that when control bit 1 is set. A read with detection on whose stored parity disagrees asserts `rspErr` in its response cycle and still returns the raw data.
- R5: With control bit 0 (detection enable) clear, reads never assert `rspErr` and never change the status register.
- R6: On a detected mismatch, in the cycle after the response the status register (`regSel`=1) shows bit 0 set, the failing-lane mask in bits 4+ (bit 4+i for lane i) and the word address in bits 16+. `irq` equals status bit 0.
- R7: While status bit 0 is set, further mismatches still assert `rspErr` but leave the captured status unchanged.
- R8: A register write to `regSel`=1 with data bit 0 set clears the status and `irq`. Writing 0 there has no effect. A mismatch in the same cycle as a clear is captured.
- R9: Setting the detection enable never sets any status bit by itself.
- R10: Rewriting a corrupted lane with control bit 1 clear restores good parity, and later reads of that word report no error.
- R11: Write responses never assert `rspErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request can be accepted (low during clear sweep) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Write data |
| reqBe | input | DATA_W/8 | Byte-lane write enables |
| rspValid | output | 1 | Response valid, one cycle after acceptance |
| rspRdata | output | DATA_W | Read data (raw, even on error) |
| rspErr | output | 1 | Parity error on this read response |
| regWr | input | 1 | Register write strobe |
| regSel | input | 1 | 0 = control, 1 = status |
| regWdata | input | 2 | Register write data (control bits; status bit 0 clears) |
| regRdata | output | 32 | Selected register contents |
| irq | output | 1 | Sticky parity error interrupt |

## Verification
The bench builds the wrapper with DEPTH set to 64 and DATA_W left at 32. This keeps the reset sweep short, so waiting it out and probing the top address 63 both fit in a handful of cycles. The fault-planting control bit is the lever that reaches every error path. With it the bench corrupts single chosen lanes, repairs them, and lines up a status clear in the same cycle as a fresh mismatch.

// File: rtl/par_guard_pkg.sv
package par_guard_pkg;

  typedef struct packed {
    logic wrEn;     // request write, per-lane gated by byte enables
    logic rdEn;     // request read, captures word and parity
    logic initWr;   // clear sweep write, all lanes
    logic flipPar;  // store inverted parity on written lanes
  } memStrobe_t;

  localparam int CTRL_W        = 2;
  localparam int CTRL_DET_BIT  = 0;
  localparam int CTRL_FLIP_BIT = 1;
  localparam int REG_W         = 32;
  localparam int STAT_FLAG_BIT = 0;
  localparam int STAT_MASK_LSB = 4;
  localparam int STAT_ADDR_LSB = 16;

  function automatic logic evenPar(input logic [7:0] b);
    return ^b;
  endfunction

endpackage

// File: rtl/par_guard_dp.sv
module par_guard_dp
  import par_guard_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        stb,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] rdData,
  output logic [LANES-1:0]  laneMis
);

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [7:0] laneMem [DEPTH];
    logic       lanePar [DEPTH];
    logic [7:0] rdByteQ;
    logic       rdParQ;
    logic [7:0] wByte;

    assign wByte = wdata[g*8 +: 8];

    always_ff @(posedge clk) begin
      if (stb.initWr) begin
        laneMem[memAddr] <= 8'h00;
        lanePar[memAddr] <= 1'b0;
      end else if (stb.wrEn && be[g]) begin
        laneMem[memAddr] <= wByte;
        lanePar[memAddr] <= evenPar(wByte) ^ stb.flipPar;
      end
    end

    always_ff @(posedge clk) begin
      if (stb.rdEn) begin
        rdByteQ <= laneMem[memAddr];
        rdParQ  <= lanePar[memAddr];
      end
    end

    assign rdData[g*8 +: 8] = rdByteQ;
    assign laneMis[g]       = evenPar(rdByteQ) ^ rdParQ;
  end

  // R4
  fresh_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stb.wrEn && !stb.flipPar && !stb.initWr) && ($past(be) == '1)
     && stb.rdEn && (memAddr == $past(memAddr))) |=> (laneMis == '0));

endmodule

// File: rtl/par_guard_ctrl.sv
module par_guard_ctrl
  import par_guard_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = 10,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              regWr,
  input  logic              regSel,
  input  logic [CTRL_W-1:0] regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic [LANES-1:0]  laneMis,
  output memStrobe_t        stb,
  output logic [ADDR_W-1:0] memAddr,
  output logic              rspValid,
  output logic              rspErr,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic              initBusy;
  logic [ADDR_W-1:0] initCnt;
  logic [CTRL_W-1:0] ctrlQ;
  logic              detEn;
  logic              accepted;
  logic              rdPendQ;
  logic              chkQ;
  logic [ADDR_W-1:0] addrQ;
  logic [LANES-1:0]  laneHit;
  logic              clrReq;
  logic              statFlag;
  logic [LANES-1:0]  statMask;
  logic [ADDR_W-1:0] statAddr;
  logic [REG_W-1:0]  statWord;

  // clear sweep after reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initBusy <= 1'b1;
      initCnt  <= '0;
    end else if (initBusy) begin
      initCnt <= initCnt + 1'b1;
      if (initCnt == LAST_ADDR) initBusy <= 1'b0;
    end
  end

  assign reqReady = !initBusy;
  assign accepted = reqValid && reqReady;
  assign detEn    = ctrlQ[CTRL_DET_BIT];

  always_comb begin
    stb.wrEn    = accepted && reqWrite;
    stb.rdEn    = accepted && !reqWrite;
    stb.initWr  = initBusy;
    stb.flipPar = ctrlQ[CTRL_FLIP_BIT];
    memAddr     = initBusy ? initCnt : reqAddr;
  end

  // response pipeline
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rdPendQ  <= 1'b0;
      chkQ     <= 1'b0;
      addrQ    <= '0;
    end else begin
      rspValid <= accepted;
      rdPendQ  <= accepted && !reqWrite;
      chkQ     <= detEn;
      if (accepted) addrQ <= reqAddr;
    end
  end

  assign laneHit = (rdPendQ && chkQ) ? laneMis : '0;
  assign rspErr  = |laneHit;

  // registers
  assign clrReq = regWr && regSel && regWdata[STAT_FLAG_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (regWr && !regSel) begin
      ctrlQ <= regWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statFlag <= 1'b0;
      statMask <= '0;
      statAddr <= '0;
    end else if (rspErr && (!statFlag || clrReq)) begin
      statFlag <= 1'b1;
      statMask <= laneHit;
      statAddr <= addrQ;
    end else if (clrReq) begin
      statFlag <= 1'b0;
      statMask <= '0;
      statAddr <= '0;
    end
  end

  always_comb begin
    statWord = '0;
    statWord[STAT_FLAG_BIT]          = statFlag;
    statWord[STAT_MASK_LSB +: LANES] = statMask;
    statWord[STAT_ADDR_LSB +: ADDR_W] = statAddr;
    regRdata = regSel ? statWord : REG_W'(ctrlQ);
  end

  assign irq = statFlag;

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid && reqReady));

  // R11
  wr_rsp_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && $past(reqWrite)) |-> !rspErr);

  // R5
  det_off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !$past(ctrlQ[CTRL_DET_BIT])) |-> !rspErr);

  // R6
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |=> irq);

  // R7
  first_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statFlag && !clrReq) |=> (statFlag && $stable(statAddr) && $stable(statMask)));

  // R9
  enable_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rspErr && !statFlag) |=> !statFlag);

endmodule

// File: rtl/par_guard_ram.sv
module par_guard_ram
  import par_guard_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqBe,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspErr,
  input  logic              regWr,
  input  logic              regSel,
  input  logic [CTRL_W-1:0] regWdata,
  output logic [REG_W-1:0]  regRdata,
  output logic              irq
);

  memStrobe_t        stb;
  logic [ADDR_W-1:0] memAddr;
  logic [LANES-1:0]  laneMis;

  par_guard_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LANES(LANES)) uCtrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .regWr(regWr), .regSel(regSel), .regWdata(regWdata), .regRdata(regRdata),
    .laneMis(laneMis), .stb(stb), .memAddr(memAddr),
    .rspValid(rspValid), .rspErr(rspErr), .irq(irq)
  );

  par_guard_dp #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANES(LANES)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .memAddr(memAddr),
    .wdata(reqWdata), .be(reqBe), .rdData(rspRdata), .laneMis(laneMis)
  );

endmodule

// File: tb/sim_par_guard_ram.sv
module sim_par_guard_ram;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int AW = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [3:0]  reqBe = '0;
  logic        rspValid;
  logic [31:0] rspRdata;
  logic        rspErr;
  logic        regWr = 1'b0;
  logic        regSel = 1'b0;
  logic [1:0]  regWdata = '0;
  logic [31:0] regRdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  par_guard_ram #(.DEPTH(DEPTH), .DATA_W(32)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe),
    .rspValid(rspValid), .rspRdata(rspRdata), .rspErr(rspErr),
    .regWr(regWr), .regSel(regSel), .regWdata(regWdata), .regRdata(regRdata), .irq(irq)
  );

  // vector: {isWr, flip, addr[5:0], be[3:0], data[31:0], expErr}
  localparam int NV = 10;
  localparam logic [44:0] VEC [NV] = '{
    {1'b1, 1'b0, 6'd5,  4'hF, 32'h11223344, 1'b0},
    {1'b0, 1'b0, 6'd5,  4'h0, 32'h11223344, 1'b0},
    {1'b1, 1'b0, 6'd5,  4'h5, 32'hAABBCCDD, 1'b0},
    {1'b0, 1'b0, 6'd5,  4'h0, 32'h11BB33DD, 1'b0},
    {1'b1, 1'b1, 6'd9,  4'h2, 32'h0000EE00, 1'b0},
    {1'b0, 1'b0, 6'd9,  4'h0, 32'h0000EE00, 1'b1},
    {1'b1, 1'b0, 6'd9,  4'h2, 32'h00007700, 1'b0},  // R10 repair
    {1'b0, 1'b0, 6'd9,  4'h0, 32'h00007700, 1'b0},
    {1'b1, 1'b0, 6'd63, 4'hF, 32'hFFFFFFFF, 1'b0},
    {1'b0, 1'b0, 6'd63, 4'h0, 32'hFFFFFFFF, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [3:0] be,
                        input logic [31:0] d, output logic [31:0] rd, output bit err, output bit vld);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqBe = be; reqWdata = d;
    @(negedge clk);
    rd = rspRdata; err = rspErr; vld = rspValid;
    reqValid = 1'b0; reqWrite = 1'b0; reqBe = '0;
  endtask

  task automatic regWrite(input bit sel, input logic [1:0] d);
    @(negedge clk);
    regWr = 1'b1; regSel = sel; regWdata = d;
    @(negedge clk);
    regWr = 1'b0; regWdata = '0;
  endtask

  task automatic regRead(input bit sel, output logic [31:0] v);
    @(negedge clk);
    regSel = sel;
    #1 v = regRdata;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    finishRun();
  end

  initial begin
    logic [31:0] rd, v;
    bit err, vld;
    bit curFlip = 0;
    int waitCnt = 0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(reqReady == 1'b0, "R1 ready low during sweep", 32'(reqReady), 32'h0);
    check(irq == 1'b0, "R1 irq after reset", 32'(irq), 32'h0);
    regRead(1'b0, v); check(v == 32'h0, "R1 control after reset", v, 32'h0);
    regRead(1'b1, v); check(v == 32'h0, "R1 status after reset", v, 32'h0);
    while (!reqReady && waitCnt < DEPTH + 4) begin
      @(negedge clk); waitCnt++;
    end
    check(reqReady == 1'b1, "R1 ready after sweep", 32'(reqReady), 32'h1);

    // R9 enabling detection alone leaves status clear
    regWrite(1'b0, 2'b01);
    repeat (4) @(negedge clk);
    regRead(1'b1, v); check(v == 32'h0, "R9 status after enable", v, 32'h0);
    check(irq == 1'b0, "R9 irq after enable", 32'(irq), 32'h0);

    access(1'b0, 6'd0, 4'h0, 32'h0, rd, err, vld);
    check(rd == 32'h0 && !err, "R1 cleared word 0", rd, 32'h0);
    access(1'b0, 6'd63, 4'h0, 32'h0, rd, err, vld);
    check(rd == 32'h0 && !err, "R1 cleared word 63", rd, 32'h0);

    // table walk, detection on
    for (int i = 0; i < NV; i++) begin
      logic [44:0] e;
      e = VEC[i];
      if (e[43] != curFlip) begin
        curFlip = e[43];
        regWrite(1'b0, {curFlip, 1'b1});
      end
      access(e[44], e[42:37], e[36:33], e[32:1], rd, err, vld);
      check(vld, "R2 response valid", 32'(vld), 32'h1);
      if (e[44]) begin
        check(!err, "R11 write response error", 32'(err), 32'h0);
      end else begin
        check(rd == e[32:1], "R2/R3 read data", rd, e[32:1]);
        check(err == e[0], e[0] ? "R4 mismatch flagged" : "R10 clean read", 32'(err), 32'(e[0]));
      end
    end
    if (curFlip) regWrite(1'b0, 2'b01);

    // R6 captured details
    regRead(1'b1, v); check(v == 32'h00090021, "R6 status capture", v, 32'h00090021);
    check(irq == 1'b1, "R6 irq set", 32'(irq), 32'h1);

    // R7 second error keeps first capture
    regWrite(1'b0, 2'b11);
    access(1'b1, 6'd12, 4'h8, 32'h5A000000, rd, err, vld);
    regWrite(1'b0, 2'b01);
    access(1'b0, 6'd12, 4'h0, 32'h0, rd, err, vld);
    check(err, "R7 later error on response", 32'(err), 32'h1);
    check(rd == 32'h5A000000, "R4 raw data on error", rd, 32'h5A000000);
    regRead(1'b1, v); check(v == 32'h00090021, "R7 status held", v, 32'h00090021);

    // R8 write-one-to-clear
    regWrite(1'b1, 2'b00);
    regRead(1'b1, v); check(v == 32'h00090021, "R8 write zero ignored", v, 32'h00090021);
    regWrite(1'b1, 2'b01);
    regRead(1'b1, v); check(v == 32'h0, "R8 status cleared", v, 32'h0);
    check(irq == 1'b0, "R8 irq cleared", 32'(irq), 32'h0);

    // R5 detection off
    regWrite(1'b0, 2'b00);
    access(1'b0, 6'd12, 4'h0, 32'h0, rd, err, vld);
    check(!err, "R5 no error when disabled", 32'(err), 32'h0);
    regRead(1'b1, v); check(v == 32'h0, "R5 status untouched", v, 32'h0);

    // R6 second capture with new lane and address
    regWrite(1'b0, 2'b01);
    access(1'b0, 6'd12, 4'h0, 32'h0, rd, err, vld);
    regRead(1'b1, v); check(v == 32'h000C0081, "R6 lane 3 capture", v, 32'h000C0081);

    // R8 clear coinciding with new mismatch: new error captured
    regWrite(1'b0, 2'b11);
    access(1'b1, 6'd20, 4'h1, 32'h000000C3, rd, err, vld);
    regWrite(1'b0, 2'b01);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 6'd20;
    @(negedge clk);
    err = rspErr;
    reqValid = 1'b0;
    regWr = 1'b1; regSel = 1'b1; regWdata = 2'b01;
    @(negedge clk);
    regWr = 1'b0; regWdata = '0;
    check(err, "R8 mismatch during clear", 32'(err), 32'h1);
    regRead(1'b1, v); check(v == 32'h00140011, "R8 set wins over clear", v, 32'h00140011);

    finishRun();
  end

endmodule